// File: doc/BRIEF.md
# Coarse-Fine Rotation Sine/Cosine Generator

This block turns a phase word into a cosine and sine pair with high amplitude precision. The phase word is 19 bits wide. The three most significant bits select one of eight octants of the circle. The remaining residual angle is then folded into the first octant: in odd octants its bits are complemented.

The folded residual is split into a coarse field and a fine field. The coarse field reads a small table of exact I/Q values at coarse angle steps. The fine field reads a second small table of I/Q values for the leftover rotation. One exact complex multiply rotates the coarse vector by the fine vector. The product is rescaled and rounded. Last, an octant map swaps and negates the pair to restore the true angle.

A sample enters with a valid strobe and leaves five clocks later with a matching valid. The block accepts a new sample on every clock. It is the phase-to-amplitude stage of a frequency synthesizer. The phase accumulator in front of it and any DAC filtering behind it are outside this block.

Top module: `cfrot_sincos`

## Requirements
- R1: The phase word `phase_i[18:0]` is decoded as follows. Bits [18:16] are the octant, bits [15:8] are the coarse field and bits [7:0] are the fine field. The output stands for the angle (phase + 0.5)·2π/2^19 rad, which is a half-step offset that keeps each octant mirror exact.
- R2: For every phase, `cos_o` and `sin_o` each lie within 2 LSB of 131071·cos and 131071·sin of the angle in R1.
- R3: `out_vld_o` equals `phase_vld_i` delayed by exactly 5 clock cycles. A sample driven before rising edge k is presented on the outputs after rising edge k+4.
- R4: Mirror symmetry is bit-exact. For p in octant 0 (bits [18:16] = 0), cos(p) = sin(2^17−1−p) and sin(p) = cos(2^17−1−p).
- R5: A half-turn is bit-exact. For every p, cos(p+2^18) = −cos(p) and sin(p+2^18) = −sin(p).
- R6: A quarter-turn is bit-exact. For every p, cos(p+2^17) = −sin(p) and sin(p+2^17) = cos(p).
- R7: While `out_vld_o` is high, both outputs stay within ±131071.
- R8: While `rst_n` is low, `out_vld_o`, `cos_o` and `sin_o` are all zero from the next clock on.
- R9: Samples driven on consecutive cycles each produce their own correct result, with no stall between them.
- R10: A phase presented with `phase_vld_i` low changes nothing. While `out_vld_o` is low, `cos_o` and `sin_o` hold the last valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| phase_i | input | 19 | Phase word: octant, coarse and fine fields |
| phase_vld_i | input | 1 | Phase word qualifier |
| cos_o | output | 18 | Signed cosine, full scale 131071 |
| sin_o | output | 18 | Signed sine, full scale 131071 |
| out_vld_o | output | 1 | Result qualifier, 5 cycles after input |

## Verification
The bench first walks a table of octant-centre and octant-edge phases. The centre phases check each octant's sign pattern, which separates a wrong swap from a wrong negation. The edge phases probe the complemented residual and the rounding near zero and full scale.

A back-to-back sweep over every fifth phase word compares each result against a real-valued reference within 2 LSB. Because the sweep runs back to back, it also catches a misaligned pipeline stage.

Directed pairs of phases test the mirror, half-turn and quarter-turn identities for bit-exact equality. These identities expose errors in the fold and in the octant map that the accuracy bound alone could hide.

Gapped streams carrying wild phases with the valid strobe low show that the outputs hold their value. A mid-stream reset shows that the outputs clear.

// File: rtl/cfrot_pkg.sv
package cfrot_pkg;

    localparam int CFR_OCT_W = 3;
    localparam int CFR_CRS_W = 8;
    localparam int CFR_FIN_W = 8;
    localparam int CFR_AMP_W = 18;
    localparam real CFR_PI = 3.14159265358979323846;

    typedef struct packed {
        logic swap;
        logic neg_c;
        logic neg_s;
    } octmap_t;

    // Octant symmetry: swap in octants 1,2,5,6; cosine negative in 2..5;
    // sine negative in 4..7.
    function automatic octmap_t decode_oct(input logic [CFR_OCT_W-1:0] oct);
        octmap_t m;
        m.swap  = oct[0] ^ oct[1];
        m.neg_c = oct[2] ^ oct[1];
        m.neg_s = oct[2];
        return m;
    endfunction

endpackage

// File: rtl/cfrot_fold.sv
module cfrot_fold #(
    parameter int OCT_W = 3,
    parameter int CRS_W = 8,
    parameter int FIN_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [OCT_W+CRS_W+FIN_W-1:0]   phase,
    input  logic                           vld,
    output logic [OCT_W-1:0]               oct_q,
    output logic [CRS_W-1:0]               crs_q,
    output logic [FIN_W-1:0]               fin_q,
    output logic                           vld_q
);
    localparam int RES_W = CRS_W + FIN_W;
    localparam int PH_W  = OCT_W + RES_W;

    logic [OCT_W-1:0] oct;
    logic [RES_W-1:0] res;
    logic [RES_W-1:0] res_f;

    always_comb begin
        oct   = phase[PH_W-1 -: OCT_W];
        res   = phase[RES_W-1:0];
        // odd octants run backwards from the octant end
        res_f = oct[0] ? ~res : res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oct_q <= '0;
            crs_q <= '0;
            fin_q <= '0;
            vld_q <= 1'b0;
        end else begin
            oct_q <= oct;
            crs_q <= res_f[RES_W-1 -: CRS_W];
            fin_q <= res_f[FIN_W-1:0];
            vld_q <= vld;
        end
    end
endmodule

// File: rtl/cfrot_rom.sv
module cfrot_rom #(
    parameter int  ADDR_W = 8,
    parameter int  AMP_W  = 18,
    parameter real STEP   = 0.0,
    parameter real OFFS   = 0.0
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       addr,
    output logic signed [AMP_W-1:0] rd_c,
    output logic signed [AMP_W-1:0] rd_s
);
    localparam int  DEPTH = 2 ** ADDR_W;
    localparam real FS_R  = real'((2 ** (AMP_W - 1)) - 1);

    logic signed [AMP_W-1:0] tab_c [DEPTH];
    logic signed [AMP_W-1:0] tab_s [DEPTH];

    // contents computed at elaboration, rounded to nearest
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        localparam real ANG = (real'(g) + OFFS) * STEP;
        assign tab_c[g] = AMP_W'(int'(FS_R * $cos(ANG)));
        assign tab_s[g] = AMP_W'(int'(FS_R * $sin(ANG)));
    end

    always_ff @(posedge clk) begin
        rd_c <= tab_c[addr];
        rd_s <= tab_s[addr];
    end
endmodule

// File: rtl/cfrot_rotate.sv
module cfrot_rotate #(
    parameter int AMP_W = 18
) (
    input  logic                    clk,
    input  logic signed [AMP_W-1:0] c_crs,
    input  logic signed [AMP_W-1:0] s_crs,
    input  logic signed [AMP_W-1:0] c_fin,
    input  logic signed [AMP_W-1:0] s_fin,
    output logic signed [AMP_W-1:0] c_out,
    output logic signed [AMP_W-1:0] s_out
);
    localparam int PW = 2 * AMP_W;
    localparam int SW = PW + 1;
    localparam int SH = AMP_W - 1;
    localparam logic signed [SW:0] HALF = (SW+1)'(1) <<< (SH - 1);
    localparam logic signed [SW:0] FS_X = (SW+1)'((2 ** (AMP_W - 1)) - 1);

    logic signed [PW-1:0] p_cc, p_ss, p_cs, p_sc;
    logic signed [SW-1:0] sum_c, sum_s;

    // stage 3: four exact products
    always_ff @(posedge clk) begin
        p_cc <= c_crs * c_fin;
        p_ss <= s_crs * s_fin;
        p_cs <= c_crs * s_fin;
        p_sc <= s_crs * c_fin;
    end

    always_comb begin
        sum_c = SW'(p_cc) - SW'(p_ss);
        sum_s = SW'(p_cs) + SW'(p_sc);
    end

    // divide by (2^SH - 1) as v*(1 + 2^-SH)/2^SH, round half up, clamp
    function automatic logic signed [AMP_W-1:0] rescale(input logic signed [SW-1:0] v);
        logic signed [SW:0] t;
        logic signed [SW:0] q;
        t = (SW+1)'(v) + (SW+1)'(v >>> SH) + HALF;
        q = t >>> SH;
        if (q > FS_X)       return AMP_W'(FS_X);
        else if (q < -FS_X) return AMP_W'(-FS_X);
        else                return AMP_W'(q);
    endfunction

    // stage 4: rounded rotation result
    always_ff @(posedge clk) begin
        c_out <= rescale(sum_c);
        s_out <= rescale(sum_s);
    end
endmodule

// File: rtl/cfrot_octmap.sv
module cfrot_octmap
    import cfrot_pkg::*;
#(
    parameter int AMP_W = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vld,
    input  logic [CFR_OCT_W-1:0]    oct,
    input  logic signed [AMP_W-1:0] c_in,
    input  logic signed [AMP_W-1:0] s_in,
    output logic signed [AMP_W-1:0] c_o,
    output logic signed [AMP_W-1:0] s_o,
    output logic                    vld_o
);
    octmap_t m;
    logic signed [AMP_W-1:0] c_sw, s_sw;

    always_comb begin
        m    = decode_oct(oct);
        c_sw = m.swap ? s_in : c_in;
        s_sw = m.swap ? c_in : s_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_o   <= '0;
            s_o   <= '0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld;
            if (vld) begin
                c_o <= m.neg_c ? -c_sw : c_sw;
                s_o <= m.neg_s ? -s_sw : s_sw;
            end
        end
    end
endmodule

// File: rtl/cfrot_sincos.sv
module cfrot_sincos
    import cfrot_pkg::*;
#(
    parameter int CRS_W = CFR_CRS_W,
    parameter int FIN_W = CFR_FIN_W,
    parameter int AMP_W = CFR_AMP_W
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [CFR_OCT_W+CRS_W+FIN_W-1:0]      phase_i,
    input  logic                                  phase_vld_i,
    output logic signed [AMP_W-1:0]               cos_o,
    output logic signed [AMP_W-1:0]               sin_o,
    output logic                                  out_vld_o
);
    localparam real OCT_ANG = CFR_PI / 4.0;
    localparam real CRS_STEP = OCT_ANG / real'(2 ** CRS_W);
    localparam real FIN_STEP = OCT_ANG / real'(2 ** (CRS_W + FIN_W));
    localparam int  FIRST_SR = 2;
    localparam int  LAST_SR  = 4;

    logic [CFR_OCT_W-1:0] oct1;
    logic [CRS_W-1:0]     crs1;
    logic [FIN_W-1:0]     fin1;
    logic                 vld1;

    // stage 1: fold into first octant
    cfrot_fold #(.OCT_W(CFR_OCT_W), .CRS_W(CRS_W), .FIN_W(FIN_W)) i_fold (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase_i),
        .vld   (phase_vld_i),
        .oct_q (oct1),
        .crs_q (crs1),
        .fin_q (fin1),
        .vld_q (vld1)
    );

    // stage 2: table reads
    logic signed [AMP_W-1:0] c_crs, s_crs, c_fin, s_fin;

    cfrot_rom #(.ADDR_W(CRS_W), .AMP_W(AMP_W), .STEP(CRS_STEP), .OFFS(0.0)) i_rom_crs (
        .clk  (clk),
        .addr (crs1),
        .rd_c (c_crs),
        .rd_s (s_crs)
    );

    cfrot_rom #(.ADDR_W(FIN_W), .AMP_W(AMP_W), .STEP(FIN_STEP), .OFFS(0.5)) i_rom_fin (
        .clk  (clk),
        .addr (fin1),
        .rd_c (c_fin),
        .rd_s (s_fin)
    );

    // stages 3 and 4: rotation
    logic signed [AMP_W-1:0] c_rot, s_rot;

    cfrot_rotate #(.AMP_W(AMP_W)) i_rotate (
        .clk   (clk),
        .c_crs (c_crs),
        .s_crs (s_crs),
        .c_fin (c_fin),
        .s_fin (s_fin),
        .c_out (c_rot),
        .s_out (s_rot)
    );

    // side-band delay for octant and valid, stages 2..4
    logic [CFR_OCT_W-1:0] oct_sr [FIRST_SR:LAST_SR];
    logic                 vld_sr [FIRST_SR:LAST_SR];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = FIRST_SR; k <= LAST_SR; k++) begin
                oct_sr[k] <= '0;
                vld_sr[k] <= 1'b0;
            end
        end else begin
            oct_sr[FIRST_SR] <= oct1;
            vld_sr[FIRST_SR] <= vld1;
            for (int k = FIRST_SR + 1; k <= LAST_SR; k++) begin
                oct_sr[k] <= oct_sr[k-1];
                vld_sr[k] <= vld_sr[k-1];
            end
        end
    end

    // stage 5: restore octant
    cfrot_octmap #(.AMP_W(AMP_W)) i_octmap (
        .clk   (clk),
        .rst_n (rst_n),
        .vld   (vld_sr[LAST_SR]),
        .oct   (oct_sr[LAST_SR]),
        .c_in  (c_rot),
        .s_in  (s_rot),
        .c_o   (cos_o),
        .s_o   (sin_o),
        .vld_o (out_vld_o)
    );
endmodule

// File: rtl/cfrot_sincos_chk.sv
module cfrot_sincos_chk #(
    parameter int AMP_W = 18
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    phase_vld_i,
    input logic signed [AMP_W-1:0] cos_o,
    input logic signed [AMP_W-1:0] sin_o,
    input logic                    out_vld_o
);
    localparam logic signed [AMP_W-1:0] FS = AMP_W'((2 ** (AMP_W - 1)) - 1);
    localparam int LAT = 5;

    logic [2:0] warm;

    always_ff @(posedge clk) begin
        if (!rst_n)        warm <= '0;
        else if (warm < 3'(LAT)) warm <= warm + 3'd1;
    end

    // R3
    latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 3'(LAT)) |-> (out_vld_o == $past(phase_vld_i, 5)));

    // R7
    cos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_o |-> (cos_o <= FS && cos_o >= -FS));

    // R7
    sin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_o |-> (sin_o <= FS && sin_o >= -FS));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_vld_o && cos_o == '0 && sin_o == '0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 3'd0 && !out_vld_o) |-> ($stable(cos_o) && $stable(sin_o)));
endmodule

bind cfrot_sincos cfrot_sincos_chk #(.AMP_W(AMP_W)) i_cfrot_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_vld_i (phase_vld_i),
    .cos_o       (cos_o),
    .sin_o       (sin_o),
    .out_vld_o   (out_vld_o)
);

// File: tb/test_cfrot_sincos.sv
`timescale 1ns/1ps
module test_cfrot_sincos;

    localparam int  PH_W  = 19;
    localparam int  AMP_W = 18;
    localparam int  FS    = 131071;
    localparam real TWO_PI = 6.28318530717958647692;
    localparam int  STRIDE = 5;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [PH_W-1:0]         phase_i = '0;
    logic                    phase_vld_i = 1'b0;
    logic signed [AMP_W-1:0] cos_o, sin_o;
    logic                    out_vld_o;

    always #2.5 clk = ~clk;

    cfrot_sincos i_cfrot_sincos (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_i     (phase_i),
        .phase_vld_i (phase_vld_i),
        .cos_o       (cos_o),
        .sin_o       (sin_o),
        .out_vld_o   (out_vld_o)
    );

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            chk_sgn;
        logic            neg_c;
        logic            neg_s;
    } vec_t;

    // octant centres (sign pattern checked) and octant edges (accuracy only)
    localparam vec_t VECS [16] = '{
        '{19'h08000, 1'b1, 1'b0, 1'b0},
        '{19'h18000, 1'b1, 1'b0, 1'b0},
        '{19'h28000, 1'b1, 1'b1, 1'b0},
        '{19'h38000, 1'b1, 1'b1, 1'b0},
        '{19'h48000, 1'b1, 1'b1, 1'b1},
        '{19'h58000, 1'b1, 1'b1, 1'b1},
        '{19'h68000, 1'b1, 1'b0, 1'b1},
        '{19'h78000, 1'b1, 1'b0, 1'b1},
        '{19'h00000, 1'b0, 1'b0, 1'b0},
        '{19'h0FFFF, 1'b0, 1'b0, 1'b0},
        '{19'h10000, 1'b0, 1'b0, 1'b0},
        '{19'h1FFFF, 1'b0, 1'b0, 1'b0},
        '{19'h20000, 1'b0, 1'b0, 1'b0},
        '{19'h3FF00, 1'b0, 1'b0, 1'b0},
        '{19'h400FF, 1'b0, 1'b0, 1'b0},
        '{19'h7FFFF, 1'b0, 1'b0, 1'b0}
    };

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [PH_W-1:0] hist_p [8];
    logic            hist_v [8];
    int              wp = 0;
    logic signed [AMP_W-1:0] last_c = '0, last_s = '0;

    task automatic chk_int(input bit ok, input string req, input string what,
                           input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_hist();
        for (int k = 0; k < 8; k++) begin
            hist_v[k] = 1'b0;
            hist_p[k] = '0;
        end
        wp = 0;
    endtask

    // compares the outputs with the sample driven five steps earlier
    task automatic check_out();
        int  s;
        real ang, ec, es;
        s = (wp + 3) & 7;
        chk_int(out_vld_o == hist_v[s], "R3", "valid", int'(out_vld_o), int'(hist_v[s]));
        if (hist_v[s]) begin
            ang = (real'(hist_p[s]) + 0.5) * TWO_PI / real'(2 ** PH_W);
            ec = real'(FS) * $cos(ang);
            es = real'(FS) * $sin(ang);
            checks++;
            if ((real'(cos_o) - ec > 2.0) || (ec - real'(cos_o) > 2.0) ||
                (real'(sin_o) - es > 2.0) || (es - real'(sin_o) > 2.0)) begin
                errors++;
                $display("FAIL R2/R9 phase %h: actual (%0d,%0d) expected (%f,%f)",
                         hist_p[s], cos_o, sin_o, ec, es);
            end
            chk_int(cos_o <= FS && cos_o >= -FS && sin_o <= FS && sin_o >= -FS,
                    "R7", "range cos", int'(cos_o), FS);
            last_c = cos_o;
            last_s = sin_o;
        end else begin
            chk_int(cos_o == last_c && sin_o == last_s, "R10", "hold cos",
                    int'(cos_o), int'(last_c));
        end
    endtask

    task automatic step(input logic [PH_W-1:0] p, input logic v);
        @(negedge clk);
        check_out();
        phase_i     = p;
        phase_vld_i = v;
        hist_p[wp & 7] = p;
        hist_v[wp & 7] = v;
        wp++;
    endtask

    task automatic measure(input logic [PH_W-1:0] p,
                           output logic signed [AMP_W-1:0] c,
                           output logic signed [AMP_W-1:0] s);
        step(p, 1'b1);
        for (int k = 0; k < 5; k++) step('0, 1'b0);
        c = cos_o;
        s = sin_o;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        logic signed [AMP_W-1:0] c0, s0, c1, s1;
        clear_hist();
        repeat (4) @(negedge clk);
        // R8: outputs clear while in reset
        chk_int(out_vld_o == 1'b0, "R8", "valid in reset", int'(out_vld_o), 0);
        chk_int(cos_o == 0 && sin_o == 0, "R8", "data in reset", int'(cos_o), 0);
        rst_n = 1'b1;

        // R1 table: octant centres and edges, back to back
        for (int n = 0; n < 16; n++) step(VECS[n].ph, 1'b1);
        for (int k = 0; k < 5; k++) step('0, 1'b0);
        for (int n = 0; n < 16; n++) begin
            if (VECS[n].chk_sgn) begin
                measure(VECS[n].ph, c0, s0);
                chk_int((c0 < 0) == VECS[n].neg_c, "R1", "cos sign", int'(c0), int'(VECS[n].neg_c));
                chk_int((s0 < 0) == VECS[n].neg_s, "R1", "sin sign", int'(s0), int'(VECS[n].neg_s));
            end
        end

        // R4 mirror, R5 half-turn, R6 quarter-turn, exact
        for (int n = 0; n < 6; n++) begin
            logic [PH_W-1:0] p;
            p = PH_W'(n * 13107 + 3);
            measure(p, c0, s0);
            measure(PH_W'(131071) - p, c1, s1);
            chk_int(c0 == s1 && s0 == c1, "R4", "mirror", int'(c1), int'(s0));
            measure(p + PH_W'(262144), c1, s1);
            chk_int(c1 == -c0 && s1 == -s0, "R5", "half turn", int'(c1), -int'(c0));
            measure(p + PH_W'(131072), c1, s1);
            chk_int(c1 == -s0 && s1 == c0, "R6", "quarter turn", int'(c1), -int'(s0));
        end

        // R10: invalid phases change nothing
        measure(19'h12345, c0, s0);
        for (int k = 0; k < 8; k++) step(PH_W'(k * 65521), 1'b0);
        chk_int(cos_o == c0 && sin_o == s0, "R10", "ignored phase", int'(cos_o), int'(c0));

        // R2/R9: back-to-back sweep, then gapped stream
        for (int p = 0; p < (2 ** PH_W); p += STRIDE) step(PH_W'(p), 1'b1);
        for (int n = 0; n < 40; n++) step(PH_W'(n * 9973 + 1), (n % 3) != 0);
        for (int k = 0; k < 6; k++) step('0, 1'b0);

        // R8: reset in mid stream
        for (int n = 0; n < 3; n++) step(PH_W'(n * 40000), 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        phase_vld_i = 1'b1;
        @(negedge clk);
        chk_int(out_vld_o == 1'b0, "R8", "valid after reset", int'(out_vld_o), 0);
        chk_int(cos_o == 0 && sin_o == 0, "R8", "data after reset", int'(sin_o), 0);
        phase_vld_i = 1'b0;
        clear_hist();
        last_c = '0;
        last_s = '0;
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) step('0, 1'b0);
        measure(19'h5A5A5, c0, s0);

        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule